// File: doc/BRIEF.md
# Fault Isolation Register Bank

This block holds the error-reporting registers of one stack of a host-bridge controller. It sits behind a plain register port. The port has a byte address, a write strobe, 64-bit write data and 64-bit read data. The bank contains five registers: a fault register, a mask register for it, two action registers, and a first-fault register that records the first unmasked fault to appear.

Software can load the fault and mask registers directly. It can also change them through alias addresses. A write to a clear alias ANDs the data into the register. A write to a set alias ORs the data into it. Hardware error lines OR into the fault register on every clock.

Each register keeps only the bits named by the parameter `IMPL_MASK`. The default mask suits the nest-side instance. The PCI-side instance is built with `64'hFC00000000000000`.

The first-fault register is driven by a two-state machine:

- `FF_ARMED`: the register is zero and waits for a fault.
- `FF_HELD`: the register holds a one-hot capture.

Its transitions are:

- `CAPTURE` (ARMED to HELD): an unmasked fault bit rises and no write to the first-fault register happens in the same cycle.
- `RELEASE` (HELD to ARMED): any write to the first-fault register.
- `IDLE`: the machine stays in its current state in every other cycle.

Top module: `fir_bank`

## Requirements
- R1: The register index is addr shifted right by 3, and the low three address bits are ignored. The index map is 0 fault, 1 fault-clear alias, 2 fault-set alias, 3 mask, 4 mask-clear alias, 5 mask-set alias, 6 action0, 7 action1, 8 first-fault. rdata shows the addressed register combinationally, and an alias index reads back the register it modifies.
- R2: A write to index 0 loads the fault register with wdata & IMPL_MASK (default 64'hFFFFFFF000000000).
- R3: A write to index 1 sets fault to fault & wdata. A write to index 2 sets fault to fault | (wdata & IMPL_MASK).
- R4: The mask register takes wdata & IMPL_MASK at index 3, ANDs wdata in at index 4, and ORs wdata & IMPL_MASK in at index 5.
- R5: A write to index 6 or 7 loads that action register with wdata & IMPL_MASK.
- R6: Any write to index 8 clears the first-fault register to zero, whatever the data.
- R7: hw_err & IMPL_MASK is ORed into the fault register on every clock edge. It wins over a clear or direct write to the same bit in the same cycle, and hw_err bits outside IMPL_MASK have no effect.
- R8: A bit counts as new when it is 1 in the next fault value, 0 in the current fault value, and 0 in the current mask. When the first-fault register is zero and one or more bits are new, the register takes on the edge the one-hot value of the lowest-numbered new bit. It then holds until written. A write to index 8 in the same cycle wins, and the register stays zero.
- R9: A write to index 9 to 15 changes no register, and unimp_wr is 1 for exactly the cycle after that write (0 otherwise). A read of such an index returns 0.
- R10: After reset, every register reads 0 except the mask register, which reads IMPL_MASK.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | 7 | Byte address, 8-byte stride |
| wr_en | input | 1 | Write strobe |
| wdata | input | 64 | Write data |
| hw_err | input | 64 | Hardware error lines, ORed into the fault register |
| rdata | output | 64 | Read data for addr |
| unimp_wr | output | 1 | One-cycle flag after a write to an unused index |

## Verification
The hardest situation to reach is a first-fault capture that competes with something else in the same cycle. Two examples are several faults rising together, and a software clear of the first-fault register or of the fault bit itself landing on the same edge as a hardware error. Every fault starts out masked after reset, so the stimulus first opens the mask through the clear alias. It then drives hardware errors together with writes to the first-fault and fault-clear addresses on the very same edge. A random phase with sparse one-bit hardware errors keeps reopening these collisions.

// File: rtl/fir_pkg.sv
package fir_pkg;
    localparam int unsigned REG_FAULT     = 0;
    localparam int unsigned REG_FAULT_AND = 1;
    localparam int unsigned REG_FAULT_OR  = 2;
    localparam int unsigned REG_MASK      = 3;
    localparam int unsigned REG_MASK_AND  = 4;
    localparam int unsigned REG_MASK_OR   = 5;
    localparam int unsigned REG_ACT0      = 6;
    localparam int unsigned NUM_ACT       = 2;
    localparam int unsigned REG_FIRST     = REG_ACT0 + NUM_ACT;
    localparam int unsigned REG_COUNT     = REG_FIRST + 1;

    typedef enum logic {
        FF_ARMED = 1'b0,
        FF_HELD  = 1'b1
    } ff_state_e;
endpackage

// File: rtl/fir_decode.sv
module fir_decode
    import fir_pkg::*;
#(
    parameter int IDX_W = 4
) (
    input  logic [IDX_W-1:0]     idx,
    input  logic                 wr_en,
    output logic [REG_COUNT-1:0] wsel,
    output logic                 bad_wr
);
    for (genvar g = 0; g < REG_COUNT; g++) begin : g_sel
        assign wsel[g] = wr_en && (idx == IDX_W'(g));
    end

    assign bad_wr = wr_en && (idx >= IDX_W'(REG_COUNT));

    // R1
    always_comb begin
        one_sel_chk : assert ($onehot0(wsel) && !(bad_wr && (|wsel)));
    end
endmodule

// File: rtl/fir_alias_reg.sv
module fir_alias_reg #(
    parameter int               DATA_W    = 64,
    parameter logic [DATA_W-1:0] IMPL     = '1,
    parameter logic [DATA_W-1:0] RST_VAL  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_load,
    input  logic              wr_and,
    input  logic              wr_or,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_set,
    output logic [DATA_W-1:0] q,
    output logic [DATA_W-1:0] d_next
);
    logic [DATA_W-1:0] sw_val;

    always_comb begin
        sw_val = q;
        if (wr_load)     sw_val = wdata & IMPL;
        else if (wr_and) sw_val = q & wdata;
        else if (wr_or)  sw_val = q | (wdata & IMPL);
        d_next = sw_val | (hw_set & IMPL);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= RST_VAL;
        else        q <= d_next;
    end

    // R2
    impl_bits_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (q & ~IMPL) == '0);

    // R7
    hw_wins_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (|(hw_set & IMPL)) |=> ((q & $past(hw_set & IMPL)) == $past(hw_set & IMPL)));
endmodule

// File: rtl/fir_first_tracker.sv
module fir_first_tracker
    import fir_pkg::*;
#(
    parameter int DATA_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic [DATA_W-1:0] new_bits,
    output logic [DATA_W-1:0] first_q
);
    ff_state_e         state_q, state_d;
    logic [DATA_W-1:0] lowest;

    assign lowest = new_bits & (~new_bits + DATA_W'(1));

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FF_ARMED: if (!clr && (|new_bits)) state_d = FF_HELD;
            FF_HELD:  if (clr)                 state_d = FF_ARMED;
            default:                           state_d = FF_ARMED;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FF_ARMED;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                       first_q <= '0;
        else if (clr)                                     first_q <= '0;
        else if (state_q == FF_ARMED && (|new_bits))      first_q <= lowest;
    end

    // R8
    first_onehot_chk : assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(first_q));

    // R6
    first_clear_chk : assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (first_q == '0));

    // R8
    first_hold_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (first_q != '0 && !clr) |=> $stable(first_q));
endmodule

// File: rtl/fir_bank.sv
module fir_bank
    import fir_pkg::*;
#(
    parameter int                DATA_W    = 64,
    parameter int                ADDR_W    = 7,
    parameter logic [DATA_W-1:0] IMPL_MASK = 64'hFFFFFFF000000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr_en,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] hw_err,
    output logic [DATA_W-1:0] rdata,
    output logic              unimp_wr
);
    localparam int IDX_W = ADDR_W - 3;

    logic [IDX_W-1:0]     idx;
    logic [REG_COUNT-1:0] wsel;
    logic                 bad_wr;
    logic [DATA_W-1:0]    fault_q, fault_d, mask_q, mask_d, first_q, new_bits;
    logic [DATA_W-1:0]    act_q [NUM_ACT];
    logic                 unused_ofs;

    assign idx        = addr[ADDR_W-1:3];
    assign unused_ofs = ^{addr[2:0], mask_d};

    fir_decode #(.IDX_W(IDX_W)) dec_i (
        .idx(idx), .wr_en(wr_en), .wsel(wsel), .bad_wr(bad_wr)
    );

    fir_alias_reg #(.DATA_W(DATA_W), .IMPL(IMPL_MASK), .RST_VAL('0)) fault_i (
        .clk(clk), .rst_n(rst_n),
        .wr_load(wsel[REG_FAULT]), .wr_and(wsel[REG_FAULT_AND]), .wr_or(wsel[REG_FAULT_OR]),
        .wdata(wdata), .hw_set(hw_err), .q(fault_q), .d_next(fault_d)
    );

    fir_alias_reg #(.DATA_W(DATA_W), .IMPL(IMPL_MASK), .RST_VAL(IMPL_MASK)) mask_i (
        .clk(clk), .rst_n(rst_n),
        .wr_load(wsel[REG_MASK]), .wr_and(wsel[REG_MASK_AND]), .wr_or(wsel[REG_MASK_OR]),
        .wdata(wdata), .hw_set('0), .q(mask_q), .d_next(mask_d)
    );

    for (genvar a = 0; a < NUM_ACT; a++) begin : g_act
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                 act_q[a] <= '0;
            else if (wsel[REG_ACT0+a])  act_q[a] <= wdata & IMPL_MASK;
        end
    end

    assign new_bits = fault_d & ~fault_q & ~mask_q;

    fir_first_tracker #(.DATA_W(DATA_W)) first_i (
        .clk(clk), .rst_n(rst_n), .clr(wsel[REG_FIRST]),
        .new_bits(new_bits), .first_q(first_q)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) unimp_wr <= 1'b0;
        else        unimp_wr <= bad_wr;
    end

    always_comb begin
        unique case (idx)
            IDX_W'(REG_FAULT), IDX_W'(REG_FAULT_AND), IDX_W'(REG_FAULT_OR): rdata = fault_q;
            IDX_W'(REG_MASK),  IDX_W'(REG_MASK_AND),  IDX_W'(REG_MASK_OR):  rdata = mask_q;
            IDX_W'(REG_ACT0):     rdata = act_q[0];
            IDX_W'(REG_ACT0 + 1): rdata = act_q[NUM_ACT-1];
            IDX_W'(REG_FIRST):    rdata = first_q;
            default:              rdata = '0;
        endcase
    end

    // R9
    unimp_pulse_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx >= IDX_W'(REG_COUNT)) |=> unimp_wr);

    // R9
    unimp_quiet_chk : assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !unimp_wr);

    // R5
    act_write_chk : assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && idx == IDX_W'(REG_ACT0)) |=> (act_q[0] == ($past(wdata) & IMPL_MASK)));
endmodule

// File: tb/fir_bank_tb.sv
`timescale 1ns/10ps
module fir_bank_tb_top;
    localparam logic [63:0] IMPL = 64'hFFFFFFF000000000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  addr = '0;
    logic        wr_en = 1'b0;
    logic [63:0] wdata = '0;
    logic [63:0] hw_err = '0;
    logic [63:0] rdata;
    logic        unimp_wr;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [63:0] m_fault, m_mask, m_act0, m_act1, m_first;
    logic        m_unimp;

    always #2 clk = ~clk;

    fir_bank dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wdata(wdata),
        .hw_err(hw_err), .rdata(rdata), .unimp_wr(unimp_wr)
    );

    task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic [63:0] lowest_bit(logic [63:0] v);
        for (int i = 0; i < 64; i++) if (v[i]) return 64'd1 << i;
        return '0;
    endfunction

    function automatic logic [63:0] model_read(int idx);
        case (idx)
            0, 1, 2: return m_fault;
            3, 4, 5: return m_mask;
            6:       return m_act0;
            7:       return m_act1;
            8:       return m_first;
            default: return '0;
        endcase
    endfunction

    task automatic model_step(bit wr, int idx, logic [63:0] d, logic [63:0] hw);
        logic [63:0] f_n, mk_n, nb;
        f_n = m_fault;
        mk_n = m_mask;
        if (wr) begin
            case (idx)
                0: f_n  = d & IMPL;
                1: f_n  = m_fault & d;
                2: f_n  = m_fault | (d & IMPL);
                3: mk_n = d & IMPL;
                4: mk_n = m_mask & d;
                5: mk_n = m_mask | (d & IMPL);
                6: m_act0 = d & IMPL;
                7: m_act1 = d & IMPL;
                default: ;
            endcase
        end
        f_n = f_n | (hw & IMPL);
        nb = f_n & ~m_fault & ~m_mask;
        if (wr && idx == 8) m_first = '0;
        else if (m_first == '0 && nb != '0) m_first = lowest_bit(nb);
        m_unimp = wr && idx > 8;
        m_fault = f_n;
        m_mask = mk_n;
    endtask

    task automatic read_all(string tag);
        @(negedge clk);
        wr_en = 1'b0;
        hw_err = '0;
        for (int i = 0; i < 10; i++) begin
            int ri;
            ri = (i == 9) ? 13 : i;
            addr = {ri[3:0], 3'b000};
            #0.15;
            chk($sformatf("%s rd%0d", tag, ri), rdata, model_read(ri));
        end
    endtask

    task automatic op(bit wr, int idx, logic [2:0] lo, logic [63:0] d,
                      logic [63:0] hw, string tag);
        @(negedge clk);
        addr = {idx[3:0], lo};
        wr_en = wr;
        wdata = d;
        hw_err = hw;
        model_step(wr, idx, d, hw);
        @(posedge clk);
        #0.1;
        wr_en = 1'b0;
        hw_err = '0;
        chk({tag, " R9 unimp_wr"}, {63'd0, unimp_wr}, {63'd0, m_unimp});
        read_all(tag);
    endtask

    initial begin
        #(4.0 * 150000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5EED1234));
        m_fault = '0; m_mask = IMPL; m_act0 = '0; m_act1 = '0; m_first = '0; m_unimp = 0;
        repeat (3) @(posedge clk);
        // R10 reset values
        read_all("R10 reset");
        chk("R10 unimp_wr", {63'd0, unimp_wr}, 64'd0);
        @(negedge clk);
        rst_n = 1'b1;
        read_all("R10 after release");

        // R2 direct fault load keeps implemented bits only
        op(1, 0, 3'b000, '1, '0, "R2 load ones");
        // R3 clear alias ANDs, set alias ORs
        op(1, 1, 3'b000, 64'h7FFFFFFFFFFFFFFF, '0, "R3 and alias");
        op(1, 0, 3'b000, '0, '0, "R2 load zero");
        op(1, 2, 3'b000, 64'h0000_0050_0000_FFFF, '0, "R3 or alias");
        // R1 low address bits ignored
        op(1, 1, 3'b101, 64'hFFFF_FFEF_FFFF_FFFF, '0, "R1 unaligned and alias");
        // R4 mask load / and / or
        op(1, 3, 3'b000, 64'h1234_5678_9ABC_DEF0, '0, "R4 mask load");
        op(1, 5, 3'b000, 64'hF000_0000_0000_000F, '0, "R4 mask or");
        op(1, 4, 3'b000, 64'h0000_0000_FFFF_FFFF, '0, "R4 mask and unmask all");
        // R5 action registers
        op(1, 6, 3'b000, 64'hDEAD_BEEF_CAFE_F00D, '0, "R5 act0");
        op(1, 7, 3'b011, 64'hAAAA_5555_AAAA_5555, '0, "R5 act1");
        // R8 two faults at once: lowest captured
        op(0, 0, 3'b000, '0, (64'd1 << 40) | (64'd1 << 37), "R8 dual capture");
        // R8 later fault does not replace the capture
        op(0, 0, 3'b000, '0, 64'd1 << 36, "R8 hold");
        // R6 write to first-fault clears it
        op(1, 8, 3'b000, 64'hFFFF_FFFF_FFFF_FFFF, '0, "R6 clear");
        // R8 clear and new fault on the same edge: clear wins
        op(1, 8, 3'b000, '0, 64'd1 << 50, "R8 clear vs capture");
        // R7 hardware set beats software clear of the same bit
        op(1, 1, 3'b000, '0, 64'd1 << 63, "R7 hw vs clear");
        // R7 hardware bits outside the mask have no effect
        op(0, 0, 3'b000, '0, 64'h0000_000F_FFFF_FFFF, "R7 unimpl hw bits");
        // R9 write to unused index changes nothing
        op(1, 12, 3'b000, '1, '0, "R9 unused write");
        op(1, 15, 3'b111, '1, '0, "R9 unused write top");

        // random phase
        for (int n = 0; n < 400; n++) begin
            int ri;
            logic [63:0] d, hw;
            ri = int'($urandom % 16);
            d = {$urandom, $urandom};
            hw = ($urandom % 3 == 0) ? (64'd1 << ($urandom % 64)) : 64'd0;
            if ($urandom % 8 == 0) d = (d & 64'h00FF_00FF_00FF_00FF) | 64'h0F00_0000_0000_0000;
            op(($urandom % 5) != 0, ri, 3'($urandom), d, hw, "RAND R3 R4 R7 R8");
        end

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule